// File: doc/BRIEF.md
# Way-Predicting Set-Associative Read Lookup

This block is the read path of a set-associative cache. Each set carries a small field that names the way the next read of that set is expected to hit. On a read only that way's data is fetched. The data goes to the requester at once, and the tag of that one way is compared during the same cycle. When the guess is right the read is finished in a single cycle, and a new read can be accepted in that same cycle.

When the guessed way does not hold the requested tag, or holds no valid line, the block raises a cancel strobe in the next cycle. The requester must then discard the word it just received. While the cancel strobe is high, the tags of the remaining ways are compared. One cycle later the block either supplies the correct word from the way that matched or raises a miss. After a corrected hit, the set's guess is moved to that way. After a miss the guess is left unchanged.

Lines are installed through a simple write port that sets the tag, data and valid bit of one (set, way) slot. Policy for refill, replacement and stores is outside this block. A read address is a block address: the low bits select the set and the remaining upper bits form the tag.

Top module: `wp_lookup`

## Requirements
- R1: After reset every line is invalid, every set's guessed way is 0, req_ready is 1, and rsp_valid, rsp_cancel and rsp_miss are 0.
- R2: A read is accepted on a rising edge where req_valid and req_ready are both 1. In the next cycle rsp_valid is 1 and rsp_data holds the data of the guessed way of set req_addr[IDX_W-1:0]. This happens whether or not that way's tag matches.
- R3: If the guessed way is valid and its tag equals req_addr[ADDR_W-1:IDX_W], the read takes one cycle. No cancel or miss follows, and req_ready is 1 in the cycle the data is shown.
- R4: If the guessed way is invalid or its tag differs, req_ready is 0 in the data cycle. rsp_cancel is 1 in the cycle after it, and req_ready is still 0 in that cycle.
- R5: In the cycle after rsp_cancel, if another valid way of the set holds the tag, rsp_valid is 1 with that way's data. This is the third cycle of the read. The lowest-numbered matching way wins, and req_ready is 1 in that cycle.
- R6: After a corrected hit, the set's guessed way becomes the way that matched, so the next read of that tag in that set finishes in one cycle.
- R7: If no valid way holds the tag, the third cycle shows rsp_miss = 1 with rsp_valid = 0, and the set's guessed way is unchanged.
- R8: A write on the fill port (fill_en = 1) sets the tag, data and valid bit of slot (fill_set, fill_way) at that edge. fill_line_valid = 0 invalidates the slot. A fill does not change any guessed way. Guesses are kept per set, so training one set leaves the others unchanged.
- R9: At most one of rsp_valid, rsp_cancel and rsp_miss is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Block address: {tag, set} |
| req_ready | output | 1 | A read can be accepted at this edge |
| rsp_valid | output | 1 | rsp_data carries a word (speculative in the first cycle) |
| rsp_data | output | DATA_W | Read data |
| rsp_cancel | output | 1 | Discard the word delivered in the previous cycle |
| rsp_miss | output | 1 | No way of the set holds the tag |
| fill_en | input | 1 | Install / invalidate one slot |
| fill_set | input | IDX_W | Slot set index |
| fill_way | input | WAY_W | Slot way |
| fill_tag | input | TAG_W | Tag to store |
| fill_data | input | DATA_W | Data to store |
| fill_line_valid | input | 1 | Valid bit to store |

## Verification
The speculative word is due one cycle after the accepting edge. A cancel, when there is one, comes one cycle after that word, and the corrected word or the miss comes one cycle after the cancel. A fill takes effect at its own edge and can be seen by the next read. For each accepted read, the bench works out from its own model of tags, valid bits and guesses the expected output for every cycle that read occupies, including req_ready. It pushes one entry per cycle into a queue at the accepting edge. A monitor pops one entry per cycle at the falling edge and checks the outputs against it. When the queue is empty, it checks that all outputs are quiet and that req_ready is 1. In this way every result is checked in the exact cycle in which it is due, and the cycle count of a fast or slow read is checked as well.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_SPEC    = 2'd1,
        LK_CANCEL  = 2'd2,
        LK_RESOLVE = 2'd3
    } lk_state_e;

endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 10,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        wr_vld,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_vld
);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_d [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  vld_d [SETS];

    always_comb begin
        tag_d = tag_q;
        vld_d = vld_q;
        if (wr_en) begin
            tag_d[wr_set][wr_way] = wr_tag;
            vld_d[wr_set][wr_way] = wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                end
            end
        end else begin
            tag_q <= tag_d;
            vld_q <= vld_d;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags[w] = tag_q[rd_set][w];
    end
    assign rd_vld = vld_q[rd_set];

endmodule

// File: rtl/wp_data_store.sv
module wp_data_store #(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int DATA_W = 32,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [DATA_W-1:0] rd_data
);

    // The set index extended by a way number selects one word: one way read per access.
    logic [DATA_W-1:0] mem_q [SETS][WAYS];
    logic [DATA_W-1:0] mem_d [SETS][WAYS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_set][wr_way] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem_q[s][w] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_set][rd_way];

endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way
);

    logic [WAY_W-1:0] pred_q [SETS];
    logic [WAY_W-1:0] pred_d [SETS];

    always_comb begin
        pred_d = pred_q;
        if (upd_en) begin
            pred_d[upd_set] = upd_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                pred_q[s] <= '0;
            end
        end else begin
            pred_q <= pred_d;
        end
    end

    assign rd_way = pred_q[rd_set];

endmodule

// File: rtl/wp_way_match.sv
module wp_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           look_tag,
    input  logic [WAY_W-1:0]           skip_way,
    output logic                       skip_hit,
    output logic                       alt_any,
    output logic [WAY_W-1:0]           alt_way
);

    logic [WAYS-1:0] match;
    logic [WAYS-1:0] alt_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w]     = vld[w] && (tags[w] == look_tag);
        assign alt_match[w] = match[w] && (skip_way != WAY_W'(w));
    end

    assign skip_hit = match[skip_way];
    assign alt_any  = |alt_match;

    // Lowest-numbered matching way wins.
    always_comb begin
        alt_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (alt_match[w]) begin
                alt_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
    import wp_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_cancel,
    output logic              rsp_miss,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_line_valid
);

    typedef struct packed {
        lk_state_e        st;
        logic [IDX_W-1:0] set;
        logic [TAG_W-1:0] tag;
        logic             hit;
        logic [WAY_W-1:0] way;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [WAY_W-1:0]            pred_cur;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [WAYS-1:0]             set_vld;
    logic                        pred_hit;
    logic                        alt_any;
    logic [WAY_W-1:0]            alt_way;
    logic [WAY_W-1:0]            rd_way;
    logic [DATA_W-1:0]           rd_data;
    logic                        upd_en;
    logic                        accept;

    wp_pred_table #(.WAYS(WAYS), .SETS(SETS)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_set (ctl_q.set),
        .upd_way (alt_way),
        .rd_set  (ctl_q.set),
        .rd_way  (pred_cur)
    );

    wp_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_set  (fill_set),
        .wr_way  (fill_way),
        .wr_tag  (fill_tag),
        .wr_vld  (fill_line_valid),
        .rd_set  (ctl_q.set),
        .rd_tags (set_tags),
        .rd_vld  (set_vld)
    );

    wp_data_store #(.WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_set  (fill_set),
        .wr_way  (fill_way),
        .wr_data (fill_data),
        .rd_set  (ctl_q.set),
        .rd_way  (rd_way),
        .rd_data (rd_data)
    );

    wp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags     (set_tags),
        .vld      (set_vld),
        .look_tag (ctl_q.tag),
        .skip_way (pred_cur),
        .skip_hit (pred_hit),
        .alt_any  (alt_any),
        .alt_way  (alt_way)
    );

    // Speculative cycle reads the guessed way; resolve cycle reads the matched way.
    assign rd_way = (ctl_q.st == LK_RESOLVE) ? ctl_q.way : pred_cur;

    assign req_ready = (ctl_q.st == LK_IDLE) || (ctl_q.st == LK_RESOLVE) ||
                       ((ctl_q.st == LK_SPEC) && pred_hit);
    assign accept    = req_valid && req_ready;

    always_comb begin
        ctl_d  = ctl_q;
        upd_en = 1'b0;
        if (ctl_q.st == LK_CANCEL) begin
            ctl_d.st  = LK_RESOLVE;
            ctl_d.hit = alt_any;
            ctl_d.way = alt_way;
            upd_en    = alt_any;
        end else if ((ctl_q.st == LK_SPEC) && !pred_hit) begin
            ctl_d.st = LK_CANCEL;
        end else if (accept) begin
            ctl_d.st  = LK_SPEC;
            ctl_d.set = req_addr[IDX_W-1:0];
            ctl_d.tag = req_addr[ADDR_W-1:IDX_W];
            ctl_d.hit = 1'b0;
        end else begin
            ctl_d.st = LK_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: LK_IDLE, set: '0, tag: '0, hit: 1'b0, way: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid  = (ctl_q.st == LK_SPEC) || ((ctl_q.st == LK_RESOLVE) && ctl_q.hit);
    assign rsp_cancel = (ctl_q.st == LK_CANCEL);
    assign rsp_miss   = (ctl_q.st == LK_RESOLVE) && !ctl_q.hit;
    assign rsp_data   = rsp_valid ? rd_data : '0;

    AST_CANCEL_FOLLOWS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cancel |-> $past(rsp_valid)); // R4
    AST_CANCEL_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cancel |-> !req_ready); // R4
    AST_SPEC_HIT_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LK_SPEC && req_ready) |=> !rsp_cancel); // R3
    AST_CANCEL_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cancel |=> (rsp_valid ^ rsp_miss)); // R5
    AST_HIT_TRAINS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LK_RESOLVE && ctl_q.hit) |-> (pred_cur == ctl_q.way)); // R6
    AST_MISS_KEEPS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> $stable(pred_cur)); // R7
    AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rsp_cancel, rsp_miss})); // R9

endmodule

// File: tb/wp_lookup_tb.sv
module wp_lookup_tb;

    localparam int WAYS = 4, SETS = 16, TAG_W = 10, DATA_W = 32;
    localparam int WAY_W = 2, IDX_W = 4, ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, rsp_valid, rsp_cancel, rsp_miss;
    logic [DATA_W-1:0] rsp_data;
    logic              fill_en = 1'b0;
    logic [IDX_W-1:0]  fill_set = '0;
    logic [WAY_W-1:0]  fill_way = '0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              fill_line_valid = 1'b0;

    always #2 clk = ~clk;

    wp_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_cancel(rsp_cancel), .rsp_miss(rsp_miss), .fill_en(fill_en),
        .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_data(fill_data), .fill_line_valid(fill_line_valid)
    );

    typedef struct {
        logic        v, c, m, rdy;
        logic [31:0] d;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    logic [TAG_W-1:0]  mt [SETS][WAYS];
    logic [DATA_W-1:0] md [SETS][WAYS];
    logic              mv [SETS][WAYS];
    logic [WAY_W-1:0]  mp [SETS];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic exp_t rec(input logic v, input logic c, input logic m,
                                 input logic rdy, input logic [31:0] d, input string req);
        exp_t e;
        e.v = v; e.c = c; e.m = m; e.rdy = rdy; e.d = d; e.req = req;
        return e;
    endfunction

    // Monitor: one expected entry per cycle, compared at the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = rec(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, "R9");
            chk(e.req, "rsp_valid", 32'(rsp_valid), 32'(e.v));
            chk(e.req, "rsp_cancel", 32'(rsp_cancel), 32'(e.c));
            chk(e.req, "rsp_miss", 32'(rsp_miss), 32'(e.m));
            chk(e.req, "req_ready", 32'(req_ready), 32'(e.rdy));
            if (e.v) chk(e.req, "rsp_data", rsp_data, e.d);
        end
    end

    // Called at a falling edge; returns at the falling edge where the block is ready again.
    task automatic do_read(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] s);
        logic [WAY_W-1:0] p;
        logic             fast, alt;
        logic [WAY_W-1:0] aw;
        p    = mp[s];
        fast = mv[s][p] && (mt[s][p] == t);
        alt  = 1'b0;
        aw   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (WAY_W'(w) != p && mv[s][w] && mt[s][w] == t) begin
                alt = 1'b1;
                aw  = WAY_W'(w);
            end
        end
        req_valid = 1'b1;
        req_addr  = {t, s};
        @(posedge clk);
        if (fast) begin
            exp_q.push_back(rec(1'b1, 1'b0, 1'b0, 1'b1, md[s][p], "R3"));
        end else begin
            exp_q.push_back(rec(1'b1, 1'b0, 1'b0, 1'b0, md[s][p], "R2"));
            exp_q.push_back(rec(1'b0, 1'b1, 1'b0, 1'b0, 32'h0, "R4"));
            if (alt) begin
                exp_q.push_back(rec(1'b1, 1'b0, 1'b0, 1'b1, md[s][aw], "R5"));
                mp[s] = aw;
            end else begin
                exp_q.push_back(rec(1'b0, 1'b0, 1'b1, 1'b1, 32'h0, "R7"));
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!fast) repeat (2) @(negedge clk);
    endtask

    task automatic do_fill(input logic [IDX_W-1:0] s, input logic [WAY_W-1:0] w,
                           input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d, input logic v);
        fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t; fill_data = d; fill_line_valid = v;
        @(posedge clk);
        mt[s][w] = t; md[s][w] = d; mv[s][w] = v;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < SETS; s++) begin
            mp[s] = '0;
            for (int w = 0; w < WAYS; w++) begin
                mt[s][w] = '0; md[s][w] = '0; mv[s][w] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs and ready after reset
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "rsp_cancel", 32'(rsp_cancel), 32'd0);
        chk("R1", "rsp_miss", 32'(rsp_miss), 32'd0);
        mon_on = 1'b1;
        // R1: lines start invalid, so tag 0 misses even though stored tags are zero
        do_read(10'h000, 4'd0);

        // R8: install four ways of set 3
        do_fill(4'd3, 2'd0, 10'h0A0, 32'hA000_0000, 1'b1);
        do_fill(4'd3, 2'd1, 10'h0A1, 32'hA111_1111, 1'b1);
        do_fill(4'd3, 2'd2, 10'h0A2, 32'hA222_2222, 1'b1);
        do_fill(4'd3, 2'd3, 10'h0A3, 32'hA333_3333, 1'b1);
        do_read(10'h0A0, 4'd3);   // R3 fast hit on way 0
        do_read(10'h0A2, 4'd3);   // R4/R5 cancel then corrected
        do_read(10'h0A2, 4'd3);   // R6 now fast
        do_read(10'h0A2, 4'd3);   // R3 back-to-back fast
        do_read(10'h0A0, 4'd3);   // R5 retrain to way 0
        do_read(10'h3FF, 4'd3);   // R7 miss
        do_read(10'h0A0, 4'd3);   // R7 guess unchanged: fast
        // R8: training set 3 left set 4 guessing way 0
        do_fill(4'd4, 2'd1, 10'h0A0, 32'hB444_4444, 1'b1);
        do_read(10'h0A0, 4'd4);
        // R8: invalidated slot cannot hit
        do_fill(4'd3, 2'd0, 10'h0A0, 32'hA000_0000, 1'b0);
        do_read(10'h0A0, 4'd3);
        // R8: fill does not move the guess
        do_fill(4'd3, 2'd0, 10'h0A0, 32'hC000_0000, 1'b1);
        do_read(10'h0A0, 4'd3);

        // Mixed pattern from an LFSR over four sets and a small tag pool
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:14] == 2'b00)
                do_fill({2'b00, lf[4:3]}, lf[9:8], {7'h0, lf[2:0]}, {lf, ~lf}, lf[11] | lf[12]);
            else
                do_read({7'h0, lf[2:0]}, {2'b00, lf[4:3]});
        end

        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        chk("R2", "queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule